// File: doc/BRIEF.md
# Two-Slot In-Order Issue Packet Former

This block sits at the issue stage of a two-wide in-order pipeline. Each cycle the front end offers up to two pre-decoded instructions in program order: an older lane and a younger lane. The block decides how many of them go out together in one issue packet and reports that back as a take count. Slot 0 of a packet only ever holds an ALU or branch operation. Slot 1 only ever holds a load or store. Any slot left empty goes out as a NOP, shown by its valid bit being low.

Pairing is allowed only when the older instruction is ALU or branch class and the younger is a memory operation. The memory operation must also not read the register that the ALU writes, because that result cannot be forwarded into an address in the same cycle. A load that has just issued blocks its consumers for one cycle, whichever slot they would land in. ALU results are assumed to be forwarded between packets, so they never hold anything back. When the older instruction must wait, the block raises `stall` so the front end keeps both lanes unchanged.

The packet is registered. An instruction taken in one cycle appears on the slot outputs after the next rising clock edge.

Top module: `dual_issue_packer`

## Requirements
- R1: While `rst_n` is low at a clock edge, both slot valids, `stall`, and all slot fields are cleared to zero.
- R2: An older ALU/branch instruction (class 0 = ALU, 1 = branch) followed by a younger memory instruction (class 2 = load, 3 = store) with no hazard is taken as a pair. Both take signals are high, and on the next cycle slot 0 holds the older instruction and slot 1 the younger.
- R3: A valid slot 0 always carries class 0 or 1, and a valid slot 1 always carries class 2 or 3.
- R4: When the younger memory instruction reads, on either source, the nonzero destination of the older ALU/branch instruction, only the older instruction is taken. The next packet has slot 1 invalid.
- R5: When both lanes hold the same class group, or the older lane holds a memory instruction, only the older instruction is taken. It is placed in its own class's slot and the other slot is invalid.
- R6: When the previous packet's slot 1 holds a load (class 2) with a nonzero destination that the older lane reads, nothing is taken and `stall` is high for that cycle.
- R7: When only the younger lane reads such a just-loaded register, the older instruction issues alone.
- R8: If the previous packet holds no load, `stall` stays low; ALU results feed the very next packet without delay.
- R9: Register 0 never creates a hazard, whether as a written or as a read register.
- R10: In the cycle after a stall, both slot valids are low and all slot fields keep their previous values.
- R11: `in_take1` implies `in_take0`, and a lane is taken only when it is valid. Every taken instruction appears on the slots exactly one cycle later.
- R12: With the older lane not valid, nothing is taken, `stall` is low, and the next packet is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld0 | input | 1 | Older lane holds an instruction |
| in_cls0 | input | 2 | Older lane class (0 ALU, 1 branch, 2 load, 3 store) |
| in_dst0 | input | REG_W | Older lane destination register |
| in_srca0 | input | REG_W | Older lane first source register |
| in_srcb0 | input | REG_W | Older lane second source register |
| in_vld1 | input | 1 | Younger lane holds an instruction |
| in_cls1 | input | 2 | Younger lane class |
| in_dst1 | input | REG_W | Younger lane destination register |
| in_srca1 | input | REG_W | Younger lane first source register |
| in_srcb1 | input | REG_W | Younger lane second source register |
| in_take0 | output | 1 | Older lane consumed this cycle |
| in_take1 | output | 1 | Younger lane consumed this cycle |
| stall | output | 1 | Older lane held by a load-use hazard |
| is_vld0 | output | 1 | Slot 0 (ALU/branch) valid |
| is_cls0 | output | 2 | Slot 0 class |
| is_dst0 | output | REG_W | Slot 0 destination |
| is_srca0 | output | REG_W | Slot 0 first source |
| is_srcb0 | output | REG_W | Slot 0 second source |
| is_vld1 | output | 1 | Slot 1 (load/store) valid |
| is_cls1 | output | 2 | Slot 1 class |
| is_dst1 | output | REG_W | Slot 1 destination |
| is_srca1 | output | REG_W | Slot 1 first source |
| is_srcb1 | output | REG_W | Slot 1 second source |

## Verification
The assertions take three things for granted about the front end. The younger lane is valid only when the older lane is. A lane that was not taken is offered again unchanged. The lanes always present the oldest pending instructions in program order. The bench keeps within these limits by feeding every scenario from an ordered list of instructions and advancing through it only by the take count the block reports. It never raises the younger valid alone, and it holds the lanes unchanged across a stall.

// File: rtl/dip_pkg.sv
// Shared encodings for the issue packet former.
// Assumes class codes with bit 1 set mark memory operations.
package dip_pkg;
    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_BR  = 2'd1,
        CLS_LD  = 2'd2,
        CLS_ST  = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        ISS_NONE,
        ISS_PAIR,
        ISS_OLD_ALU,
        ISS_OLD_MEM
    } iss_e;

    localparam int NUM_SLOTS = 2;
    localparam int NUM_SRCS  = 2;

    function automatic logic is_mem(input logic [1:0] cls);
        return cls[1];
    endfunction
endpackage

// File: rtl/dip_dep_cmp.sv
// Read-after-write detector: flags when any source of a reader matches a
// valid, nonzero written register. Assumes register 0 is hardwired zero.
module dip_dep_cmp #(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                       wr_vld,
    input  logic [REG_W-1:0]           wr_reg,
    input  logic [NSRC-1:0][REG_W-1:0] rd_regs,
    output logic                       hit
);
    logic [NSRC-1:0] match;

    // One comparator per source operand.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign match[s] = wr_vld && (wr_reg != '0) && (rd_regs[s] == wr_reg);
    end

    assign hit = |match;
endmodule

// File: rtl/dip_pair_sel.sv
// Chooses the issue mode for this cycle from lane classes and hazard flags.
// Assumes lane 1 is valid only together with lane 0.
module dip_pair_sel
    import dip_pkg::*;
(
    input  logic       vld0,
    input  logic [1:0] cls0,
    input  logic       vld1,
    input  logic [1:0] cls1,
    input  logic       intra_raw,
    input  logic       lu_old,
    input  logic       lu_young,
    output iss_e       mode,
    output logic       take0,
    output logic       take1,
    output logic       hold
);
    // Priority: load-use hold, then slot class, then pairing legality.
    always_comb begin
        mode = ISS_NONE;
        if (vld0 && !lu_old) begin
            if (is_mem(cls0)) begin
                mode = ISS_OLD_MEM;
            end else if (vld1 && is_mem(cls1) && !intra_raw && !lu_young) begin
                mode = ISS_PAIR;
            end else begin
                mode = ISS_OLD_ALU;
            end
        end
    end

    // Handshake back to the front end.
    always_comb begin
        take0 = (mode != ISS_NONE);
        take1 = (mode == ISS_PAIR);
        hold  = vld0 && (mode == ISS_NONE);
    end
endmodule

// File: rtl/dip_slot_reg.sv
// One issue slot register. Loads a new instruction when told to; otherwise
// drops valid and keeps its fields so held packets stay stable.
module dip_slot_reg #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       d_cls,
    input  logic [REG_W-1:0] d_dst,
    input  logic [REG_W-1:0] d_sa,
    input  logic [REG_W-1:0] d_sb,
    output logic             q_vld,
    output logic [1:0]       q_cls,
    output logic [REG_W-1:0] q_dst,
    output logic [REG_W-1:0] q_sa,
    output logic [REG_W-1:0] q_sb
);
    // Slot state update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld <= 1'b0;
            q_cls <= '0;
            q_dst <= '0;
            q_sa  <= '0;
            q_sb  <= '0;
        end else begin
            q_vld <= load;
            if (load) begin
                q_cls <= d_cls;
                q_dst <= d_dst;
                q_sa  <= d_sa;
                q_sb  <= d_sb;
            end
        end
    end
endmodule

// File: rtl/dual_issue_packer.sv
// Forms two-slot issue packets (slot 0 ALU/branch, slot 1 load/store) from
// two in-order lanes. Splits ALU-to-memory dependencies and holds consumers
// of a just-issued load for one cycle. Assumes ALU results are forwarded
// between packets and the front end replays untaken lanes unchanged.
module dual_issue_packer
    import dip_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld0,
    input  logic [1:0]       in_cls0,
    input  logic [REG_W-1:0] in_dst0,
    input  logic [REG_W-1:0] in_srca0,
    input  logic [REG_W-1:0] in_srcb0,
    input  logic             in_vld1,
    input  logic [1:0]       in_cls1,
    input  logic [REG_W-1:0] in_dst1,
    input  logic [REG_W-1:0] in_srca1,
    input  logic [REG_W-1:0] in_srcb1,
    output logic             in_take0,
    output logic             in_take1,
    output logic             stall,
    output logic             is_vld0,
    output logic [1:0]       is_cls0,
    output logic [REG_W-1:0] is_dst0,
    output logic [REG_W-1:0] is_srca0,
    output logic [REG_W-1:0] is_srcb0,
    output logic             is_vld1,
    output logic [1:0]       is_cls1,
    output logic [REG_W-1:0] is_dst1,
    output logic [REG_W-1:0] is_srca1,
    output logic [REG_W-1:0] is_srcb1
);
    localparam int NCHK   = 3;
    localparam int CHK_LU0 = 0;
    localparam int CHK_LU1 = 1;
    localparam int CHK_RAW = 2;

    logic [NCHK-1:0]                      chk_wv;
    logic [NCHK-1:0][REG_W-1:0]           chk_wr;
    logic [NCHK-1:0][NUM_SRCS-1:0][REG_W-1:0] chk_rd;
    logic [NCHK-1:0]                      chk_hit;

    logic prev_load;
    iss_e mode;

    // The previous packet's slot 1 is the only place a pending load lives.
    assign prev_load = is_vld1 && (is_cls1 == CLS_LD);

    // Wire up the three hazard comparisons.
    always_comb begin
        chk_wv[CHK_LU0] = prev_load;
        chk_wr[CHK_LU0] = is_dst1;
        chk_rd[CHK_LU0] = {in_srcb0, in_srca0};
        chk_wv[CHK_LU1] = prev_load;
        chk_wr[CHK_LU1] = is_dst1;
        chk_rd[CHK_LU1] = {in_srcb1, in_srca1};
        chk_wv[CHK_RAW] = in_vld0 && !is_mem(in_cls0);
        chk_wr[CHK_RAW] = in_dst0;
        chk_rd[CHK_RAW] = {in_srcb1, in_srca1};
    end

    for (genvar c = 0; c < NCHK; c++) begin : g_chk
        dip_dep_cmp #(.REG_W(REG_W), .NSRC(NUM_SRCS)) u_cmp (
            .wr_vld  (chk_wv[c]),
            .wr_reg  (chk_wr[c]),
            .rd_regs (chk_rd[c]),
            .hit     (chk_hit[c])
        );
    end

    dip_pair_sel u_sel (
        .vld0      (in_vld0),
        .cls0      (in_cls0),
        .vld1      (in_vld1),
        .cls1      (in_cls1),
        .intra_raw (chk_hit[CHK_RAW]),
        .lu_old    (chk_hit[CHK_LU0]),
        .lu_young  (chk_hit[CHK_LU1]),
        .mode      (mode),
        .take0     (in_take0),
        .take1     (in_take1),
        .hold      (stall)
    );

    logic [NUM_SLOTS-1:0]            sl_load;
    logic [NUM_SLOTS-1:0][1:0]       sl_cls, q_cls;
    logic [NUM_SLOTS-1:0][REG_W-1:0] sl_dst, sl_sa, sl_sb;
    logic [NUM_SLOTS-1:0][REG_W-1:0] q_dst, q_sa, q_sb;
    logic [NUM_SLOTS-1:0]            q_vld;

    // Steer lanes to slots: slot 0 always from the older lane, slot 1 from
    // the younger lane when paired, else from the older lane.
    always_comb begin
        sl_load[0] = (mode == ISS_PAIR) || (mode == ISS_OLD_ALU);
        sl_load[1] = (mode == ISS_PAIR) || (mode == ISS_OLD_MEM);
        sl_cls[0]  = in_cls0;
        sl_dst[0]  = in_dst0;
        sl_sa[0]   = in_srca0;
        sl_sb[0]   = in_srcb0;
        if (mode == ISS_PAIR) begin
            sl_cls[1] = in_cls1;
            sl_dst[1] = in_dst1;
            sl_sa[1]  = in_srca1;
            sl_sb[1]  = in_srcb1;
        end else begin
            sl_cls[1] = in_cls0;
            sl_dst[1] = in_dst0;
            sl_sa[1]  = in_srca0;
            sl_sb[1]  = in_srcb0;
        end
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        dip_slot_reg #(.REG_W(REG_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (sl_load[s]),
            .d_cls (sl_cls[s]),
            .d_dst (sl_dst[s]),
            .d_sa  (sl_sa[s]),
            .d_sb  (sl_sb[s]),
            .q_vld (q_vld[s]),
            .q_cls (q_cls[s]),
            .q_dst (q_dst[s]),
            .q_sa  (q_sa[s]),
            .q_sb  (q_sb[s])
        );
    end

    // Flatten slot registers onto the port list.
    always_comb begin
        is_vld0  = q_vld[0];
        is_cls0  = q_cls[0];
        is_dst0  = q_dst[0];
        is_srca0 = q_sa[0];
        is_srcb0 = q_sb[0];
        is_vld1  = q_vld[1];
        is_cls1  = q_cls[1];
        is_dst1  = q_dst[1];
        is_srca1 = q_sa[1];
        is_srcb1 = q_sb[1];
    end
endmodule

// File: rtl/dip_checker.sv
// Property checker for dual_issue_packer, attached by bind. Assumes lane 1
// is valid only with lane 0 and that untaken lanes are replayed unchanged.
module dip_checker #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld0,
    input logic [1:0]       in_cls0,
    input logic [REG_W-1:0] in_dst0,
    input logic [REG_W-1:0] in_srca0,
    input logic [REG_W-1:0] in_srcb0,
    input logic             in_vld1,
    input logic [1:0]       in_cls1,
    input logic [REG_W-1:0] in_dst1,
    input logic [REG_W-1:0] in_srca1,
    input logic [REG_W-1:0] in_srcb1,
    input logic             in_take0,
    input logic             in_take1,
    input logic             stall,
    input logic             is_vld0,
    input logic [1:0]       is_cls0,
    input logic [REG_W-1:0] is_dst0,
    input logic [REG_W-1:0] is_srca0,
    input logic [REG_W-1:0] is_srcb0,
    input logic             is_vld1,
    input logic [1:0]       is_cls1,
    input logic [REG_W-1:0] is_dst1,
    input logic [REG_W-1:0] is_srca1,
    input logic [REG_W-1:0] is_srcb1
);
    assert_pair_issues_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_take0 && in_take1 |=> is_vld0 && is_vld1);

    assert_slot0_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_vld0 |-> !is_cls0[1]);

    assert_slot1_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_vld1 |-> is_cls1[1]);

    assert_no_addr_raw_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_take1 |-> !((in_dst0 != '0) && ((in_srca1 == in_dst0) || (in_srcb1 == in_dst0))));

    assert_load_use_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_vld1 && (is_cls1 == 2'd2) && (is_dst1 != '0) && in_vld0 &&
        ((in_srca0 == is_dst1) || (in_srcb0 == is_dst1)) |-> stall && !in_take0);

    assert_no_stall_without_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_vld1 && (is_cls1 == 2'd2)) |-> !stall);

    assert_r0_load_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_vld1 && (is_dst1 == '0) |-> !stall);

    assert_stall_holds_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !is_vld0 && !is_vld1 && $stable(is_cls0) && $stable(is_dst0) &&
                  $stable(is_srca0) && $stable(is_srcb0) && $stable(is_cls1) &&
                  $stable(is_dst1) && $stable(is_srca1) && $stable(is_srcb1));

    assert_take_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_take1 |-> in_take0 && in_vld1) and (in_take0 |-> in_vld0));

    assert_take_shows_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_take0 |=> is_vld0 || is_vld1);

    assert_idle_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld0 |-> !stall ##1 (!is_vld0 && !is_vld1));
endmodule

bind dual_issue_packer dip_checker #(.REG_W(REG_W)) u_chk (.*);

// File: tb/dual_issue_packer_tb.sv
`timescale 1ns/1ps
// Directed bench for dual_issue_packer: one task per scenario, plus an
// in-order stream checked against a requirement-level model.
module dual_issue_packer_tb;
    localparam int RW = 5;
    typedef struct packed {
        logic [1:0]    cls;
        logic [RW-1:0] dst;
        logic [RW-1:0] sa;
        logic [RW-1:0] sb;
    } ins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic v0 = 1'b0, v1 = 1'b0;
    ins_t l0 = '0, l1 = '0;
    logic t0, t1, st;
    logic ov0, ov1;
    logic [1:0] oc0, oc1;
    logic [RW-1:0] od0, oa0, ob0, od1, oa1, ob1;

    int total = 0;
    int fails = 0;
    logic g_t0, g_t1, g_st;
    logic g_v0, g_v1;
    ins_t g_q0, g_q1;

    always #4 clk = ~clk;

    dual_issue_packer #(.REG_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_vld0(v0), .in_cls0(l0.cls), .in_dst0(l0.dst), .in_srca0(l0.sa), .in_srcb0(l0.sb),
        .in_vld1(v1), .in_cls1(l1.cls), .in_dst1(l1.dst), .in_srca1(l1.sa), .in_srcb1(l1.sb),
        .in_take0(t0), .in_take1(t1), .stall(st),
        .is_vld0(ov0), .is_cls0(oc0), .is_dst0(od0), .is_srca0(oa0), .is_srcb0(ob0),
        .is_vld1(ov1), .is_cls1(oc1), .is_dst1(od1), .is_srca1(oa1), .is_srcb1(ob1)
    );

    function automatic ins_t mk(input logic [1:0] c, input int d, input int a, input int b);
        return '{cls: c, dst: RW'(d), sa: RW'(a), sb: RW'(b)};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Drive at the falling edge, sample handshake before the rising edge,
    // then sample the packet at the following falling edge.
    task automatic cycle(input ins_t a, input logic va, input ins_t b, input logic vb);
        l0 = a; v0 = va; l1 = b; v1 = vb;
        #1;
        g_t0 = t0; g_t1 = t1; g_st = st;
        @(posedge clk);
        @(negedge clk);
        g_v0 = ov0; g_v1 = ov1;
        g_q0 = '{cls: oc0, dst: od0, sa: oa0, sb: ob0};
        g_q1 = '{cls: oc1, dst: od1, sa: oa1, sb: ob1};
    endtask

    task automatic idle();
        cycle('0, 1'b0, '0, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; v0 = 1'b0; v1 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "slot0 valid", ov0, 0);
        chk("R1", "slot1 valid", ov1, 0);
        chk("R1", "stall", st, 0);
        chk("R1", "fields", int'({od0, od1, oc0, oc1}), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_pair();
        ins_t a = mk(2'd0, 3, 1, 2);
        ins_t b = mk(2'd2, 4, 5, 0);
        idle();
        cycle(a, 1'b1, b, 1'b1);
        chk("R2", "take0", g_t0, 1);
        chk("R2", "take1", g_t1, 1);
        chk("R11", "stall", g_st, 0);
        chk("R2", "slot0", int'(g_q0), int'(a));
        chk("R2", "slot1", int'(g_q1), int'(b));
        chk("R2", "valids", int'({g_v0, g_v1}), 3);
    endtask

    task automatic t_addr_raw();
        ins_t a = mk(2'd0, 6, 1, 1);
        ins_t b = mk(2'd2, 7, 6, 0);
        idle();
        cycle(a, 1'b1, b, 1'b1);
        chk("R4", "take pair", int'({g_t0, g_t1}), 2);
        chk("R4", "valids", int'({g_v0, g_v1}), 2);
        chk("R4", "slot0", int'(g_q0), int'(a));
        cycle(b, 1'b1, '0, 1'b0);
        chk("R4", "mem next take", int'({g_t0, g_t1}), 2);
        chk("R4", "mem next valids", int'({g_v0, g_v1}), 1);
        chk("R4", "mem next slot1", int'(g_q1), int'(b));
    endtask

    task automatic t_classes();
        ins_t a = mk(2'd0, 2, 3, 4);
        ins_t br = mk(2'd1, 0, 2, 5);
        ins_t m = mk(2'd3, 0, 8, 9);
        idle();
        cycle(a, 1'b1, br, 1'b1);
        chk("R5", "alu+br take", int'({g_t0, g_t1}), 2);
        chk("R5", "alu+br valids", int'({g_v0, g_v1}), 2);
        cycle(m, 1'b1, a, 1'b1);
        chk("R5", "mem older take", int'({g_t0, g_t1}), 2);
        chk("R5", "mem older valids", int'({g_v0, g_v1}), 1);
        chk("R3", "mem older slot1", int'(g_q1), int'(m));
        cycle(m, 1'b1, m, 1'b1);
        chk("R5", "mem+mem take", int'({g_t0, g_t1}), 2);
    endtask

    task automatic t_load_use_old();
        ins_t a = mk(2'd0, 1, 2, 3);
        ins_t ld = mk(2'd2, 8, 2, 0);
        ins_t u = mk(2'd0, 9, 8, 1);
        idle();
        cycle(a, 1'b1, ld, 1'b1);
        cycle(u, 1'b1, '0, 1'b0);
        chk("R6", "stall", g_st, 1);
        chk("R6", "take0", g_t0, 0);
        chk("R10", "valids after stall", int'({g_v0, g_v1}), 0);
        chk("R10", "slot1 held", int'(g_q1), int'(ld));
        chk("R10", "slot0 held", int'(g_q0), int'(a));
        cycle(u, 1'b1, '0, 1'b0);
        chk("R6", "released stall", g_st, 0);
        chk("R6", "released slot0", int'(g_q0), int'(u));
    endtask

    task automatic t_load_use_young();
        ins_t a = mk(2'd0, 1, 2, 3);
        ins_t ld = mk(2'd2, 9, 2, 0);
        ins_t x = mk(2'd0, 4, 5, 6);
        ins_t s = mk(2'd3, 0, 2, 9);
        idle();
        cycle(a, 1'b1, ld, 1'b1);
        cycle(x, 1'b1, s, 1'b1);
        chk("R7", "stall", g_st, 0);
        chk("R7", "take", int'({g_t0, g_t1}), 2);
        chk("R7", "valids", int'({g_v0, g_v1}), 2);
    endtask

    task automatic t_alu_forward();
        ins_t a = mk(2'd0, 10, 1, 2);
        ins_t b = mk(2'd0, 11, 10, 10);
        ins_t m = mk(2'd2, 12, 10, 0);
        idle();
        cycle(a, 1'b1, '0, 1'b0);
        cycle(b, 1'b1, m, 1'b1);
        chk("R8", "stall", g_st, 0);
        chk("R8", "take", int'({g_t0, g_t1}), 3);
    endtask

    task automatic t_reg_zero();
        ins_t a = mk(2'd0, 0, 1, 2);
        ins_t ld = mk(2'd2, 0, 0, 0);
        ins_t u = mk(2'd0, 3, 0, 0);
        idle();
        cycle(a, 1'b1, ld, 1'b1);
        chk("R9", "r0 pair take", int'({g_t0, g_t1}), 3);
        cycle(u, 1'b1, '0, 1'b0);
        chk("R9", "r0 load-use stall", g_st, 0);
        chk("R9", "r0 take0", g_t0, 1);
    endtask

    task automatic t_idle();
        ins_t a = mk(2'd0, 5, 5, 5);
        cycle(a, 1'b1, '0, 1'b0);
        cycle(a, 1'b0, a, 1'b0);
        chk("R12", "take", int'({g_t0, g_t1}), 0);
        chk("R12", "stall", g_st, 0);
        chk("R12", "valids", int'({g_v0, g_v1}), 0);
    endtask

    // Requirement-level model over an in-order stream; lanes advance by the
    // model's own take count.
    task automatic t_stream();
        ins_t prog[40];
        int idx = 0;
        logic pl_v = 1'b0;
        logic [RW-1:0] pl_d = '0;
        for (int i = 0; i < 40; i++) begin
            prog[i] = mk(2'($urandom_range(0, 3)), $urandom_range(0, 3),
                         $urandom_range(0, 3), $urandom_range(0, 3));
        end
        idle();
        for (int guard = 0; guard < 200 && idx < 40; guard++) begin
            ins_t a = prog[idx];
            logic vb = (idx + 1 < 40);
            ins_t b = vb ? prog[idx + 1] : '0;
            logic e0, e1, dep_a, dep_b, raw;
            dep_a = pl_v && pl_d != 0 && (a.sa == pl_d || a.sb == pl_d);
            dep_b = pl_v && pl_d != 0 && (b.sa == pl_d || b.sb == pl_d);
            raw = a.dst != 0 && (b.sa == a.dst || b.sb == a.dst);
            e0 = !dep_a;
            e1 = e0 && vb && !a.cls[1] && b.cls[1] && !raw && !dep_b;
            cycle(a, 1'b1, b, vb);
            chk("R2-model", "stream take", int'({g_t0, g_t1}), int'({e0, e1}));
            chk("R6-model", "stream stall", g_st, int'(!e0));
            if (e1) begin
                chk("R2", "stream slot pair", int'({g_v0, g_v1, g_q0, g_q1}),
                    int'({2'b11, a, b}));
            end else if (e0) begin
                chk("R5", "stream single valids", int'({g_v0, g_v1}),
                    a.cls[1] ? 1 : 2);
                chk("R3", "stream single slot", int'(a.cls[1] ? g_q1 : g_q0), int'(a));
            end else begin
                chk("R10", "stream held valids", int'({g_v0, g_v1}), 0);
            end
            pl_v = e1 ? (b.cls == 2'd2) : (e0 && a.cls == 2'd2);
            pl_d = e1 ? b.dst : a.dst;
            idx += int'(e0) + int'(e1);
        end
        chk("R11", "stream consumed", idx, 40);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_pair();
        t_addr_raw();
        t_classes();
        t_load_use_old();
        t_load_use_young();
        t_alu_forward();
        t_reg_zero();
        t_idle();
        t_stream();
        summary();
    end
endmodule